// File: doc/BRIEF.md
# Signed Sign-Extension Array Multiplier

This block multiplies two two's-complement operands of width N (default 5) and delivers the signed product at 2N bits. A flat array forms it. Each row takes the multiplicand when one multiplier bit is set and zero when it is clear. The row is sign-extended to the product width and moved left by that bit's weight. A chain of full-width adders then adds the rows, and any carry above the top product bit is dropped.

The array only accepts a non-negative multiplier. When the multiplier is negative, both operands are first negated at N+1 bits. The N+1 width lets the most negative value flip to its positive magnitude without wrapping. The adder result is captured in one output register with a synchronous active-low reset, so the product appears one clock after the operands.

Top module: `sgnx_array_mult`

## Requirements
- R1: `product_o` is 2N bits wide. It shows the product of the operands that were present at the previous rising clock edge while `rst_n` was high, so the latency is one cycle.
- R2: If `rst_n` is low at a rising edge, `product_o` becomes all zeros.
- R3: For every pair of N-bit two's-complement operands, `product_o` read as a 2N-bit two's-complement number equals the product of the two operands.
- R4: A negative multiplicand with a positive multiplier gives the correct negative product. At N=5, -14 times +11 gives -154 (10-bit 0x366).
- R5: Two positive operands give the correct positive product. At N=5, +14 times +11 gives +154 (0x09A).
- R6: A negative multiplier gives the correct product for a multiplicand of either sign. At N=5, +14 times -11 gives -154 and -14 times -11 gives +154.
- R7: A multiplier equal to the most negative value -2^(N-1) gives the correct product. At N=5, -16 times -16 gives +256 and +15 times -16 gives -240.
- R8: If either operand is zero, the product is zero.
- R9: While both operands stay unchanged and reset is inactive, `product_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register loads on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the product register |
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement |
| product_o | output | 2N | Registered signed product |

## Verification
The likeliest internal faults are a wrong sign extension on a row, a missing or doubled row shift, and a negation that wraps at the most negative value. Each of these shows up at `product_o` in the cycle right after the faulty operand pair is applied. The fault only appears for the operand patterns that reach it: negative multiplicands, particular multiplier bits, or the -2^(N-1) multiplier. For this reason every operand pair at N=5 is applied and compared one cycle later, in addition to the named corner cases.

// File: rtl/sgnx_mult_pkg.sv
// Package: shared constants and width helpers for the signed array multiplier.
// Assumes: operand width of at least 2 bits.
package sgnx_mult_pkg;

    localparam int unsigned SGNX_DEFAULT_W = 5;

    // Width of the full product for a given operand width.
    function automatic int unsigned prod_width(input int unsigned w);
        return 2 * w;
    endfunction

endpackage

// File: rtl/sgnx_operand_prep.sv
// Module: sgnx_operand_prep
// Brings both operands to N+1 bits. If the multiplier is negative, negates
// both, so the multiplier handed on is always non-negative.
// Assumes: N >= 2. The magnitude of -2^(N-1) fits in the N low bits handed on.
module sgnx_operand_prep #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] mcand_in,
    input  logic [N-1:0] mplier_in,
    output logic [N:0]   mcand_adj,
    output logic [N-1:0] mplier_mag
);
    localparam int unsigned XW = N + 1;

    logic [XW-1:0] mcand_ext;
    logic [XW-1:0] mplier_ext;
    logic [XW-1:0] mplier_adj;
    logic          flip;

    // Widen by one sign bit and negate both operands when the multiplier is negative.
    always_comb begin
        mcand_ext  = {mcand_in[N-1], mcand_in};
        mplier_ext = {mplier_in[N-1], mplier_in};
        flip       = mplier_in[N-1];
        mcand_adj  = flip ? (~mcand_ext + 1'b1) : mcand_ext;
        mplier_adj = flip ? (~mplier_ext + 1'b1) : mplier_ext;
        mplier_mag = mplier_adj[N-1:0];
    end
endmodule

// File: rtl/sgnx_pp_rows.sv
// Module: sgnx_pp_rows
// Builds N partial-product rows. Row i is the (N+1)-bit signed multiplicand,
// sign-extended to the product width and shifted left by i, or zero when
// multiplier bit i is clear.
// Assumes: the multiplier is non-negative, so there is no negative-weight row.
module sgnx_pp_rows #(
    parameter int unsigned N  = 5,
    parameter int unsigned PW = 2 * N
) (
    input  logic [N:0]           mcand_adj,
    input  logic [N-1:0]         mplier_mag,
    output logic [N-1:0][PW-1:0] rows
);
    localparam int unsigned EXT = PW - (N + 1);

    logic [PW-1:0] mcand_full;

    // Sign-extend the adjusted multiplicand to the full product width.
    always_comb begin
        mcand_full = {{EXT{mcand_adj[N]}}, mcand_adj};
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        // Gate the shifted multiplicand with multiplier bit i.
        always_comb begin
            rows[i] = mplier_mag[i] ? (mcand_full << i) : '0;
        end
    end
endmodule

// File: rtl/sgnx_row_adder.sv
// Module: sgnx_row_adder
// Adds the partial-product rows through a chain of adders that are each
// as wide as the product. Carries out of the top bit are dropped.
// Assumes: the true product fits in PW signed bits.
module sgnx_row_adder #(
    parameter int unsigned N  = 5,
    parameter int unsigned PW = 2 * N
) (
    input  logic [N-1:0][PW-1:0] rows,
    output logic [PW-1:0]        sum
);
    logic [N:0][PW-1:0] partial;

    // Seed the chain with zero.
    always_comb begin
        partial[0] = '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_add
        // Add row i to the running total, modulo 2^PW.
        always_comb begin
            partial[i+1] = partial[i] + rows[i];
        end
    end

    // Hand on the final total.
    always_comb begin
        sum = partial[N];
    end
endmodule

// File: rtl/sgnx_array_mult.sv
// Module: sgnx_array_mult (top)
// Signed array multiplier with one output register. Operand preparation,
// row generation and row addition are combinational. product_o loads every
// cycle and is cleared by the synchronous active-low reset.
// Assumes: N >= 2.
module sgnx_array_mult
    import sgnx_mult_pkg::*;
#(
    parameter int unsigned N = SGNX_DEFAULT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             mcand_i,
    input  logic [N-1:0]             mplier_i,
    output logic [prod_width(N)-1:0] product_o
);
    localparam int unsigned PW = prod_width(N);

    logic [N:0]           mcand_adj;
    logic [N-1:0]         mplier_mag;
    logic [N-1:0][PW-1:0] rows;
    logic [PW-1:0]        sum;

    sgnx_operand_prep #(.N(N)) u_prep (
        .mcand_in   (mcand_i),
        .mplier_in  (mplier_i),
        .mcand_adj  (mcand_adj),
        .mplier_mag (mplier_mag)
    );

    sgnx_pp_rows #(.N(N), .PW(PW)) u_rows (
        .mcand_adj  (mcand_adj),
        .mplier_mag (mplier_mag),
        .rows       (rows)
    );

    sgnx_row_adder #(.N(N), .PW(PW)) u_add (
        .rows (rows),
        .sum  (sum)
    );

    // Capture the product each cycle; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product_o <= '0;
        end else begin
            product_o <= sum;
        end
    end
endmodule

// File: rtl/sgnx_array_mult_chk.sv
// Module: sgnx_array_mult_chk
// Checker bound to sgnx_array_mult. It relates the registered product to
// the operands of the previous cycle.
// Assumes: the same N as the checked instance.
module sgnx_array_mult_chk #(
    parameter int unsigned N = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   mcand_i,
    input logic [N-1:0]   mplier_i,
    input logic [2*N-1:0] product_o
);
    localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

    // R1, R3: the product equals the signed product of the previous operands.
    assert_signed_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $signed(product_o) == ($signed($past(mcand_i)) * $signed($past(mplier_i))));

    // R8: a zero operand gives a zero product.
    assert_zero_operand_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mcand_i == '0 || mplier_i == '0) |=> product_o == '0);

    // R4, R6: non-zero operands of opposite sign give a negative product.
    assert_result_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mcand_i != '0 && mplier_i != '0 && (mcand_i[N-1] ^ mplier_i[N-1]))
        |=> product_o[2*N-1]);

    // R7: the most negative multiplier scales the negated multiplicand by 2^(N-1).
    assert_most_neg_mplier_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mplier_i == MOST_NEG) |=>
        $signed(product_o) == -($signed($past(mcand_i)) * $signed({1'b0, MOST_NEG})));

    // R9: unchanged operands leave the product unchanged.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(mcand_i) && $stable(mplier_i)) |=> $stable(product_o));
endmodule

bind sgnx_array_mult sgnx_array_mult_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o)
);

// File: tb/sim_sgnx_array_mult.sv
// Bench for sgnx_array_mult at N=5: directed tasks plus an exhaustive sweep.
module sim_sgnx_array_mult;
    localparam int N  = 5;
    localparam int PW = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  mcand_i = '0;
    logic [N-1:0]  mplier_i = '0;
    logic [PW-1:0] product_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    sgnx_array_mult #(.N(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .product_o (product_o)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Applies one pair, waits through one rising edge, and checks against
    // the expected signed product.
    task automatic apply_check(input int a, input int b, input int exp, input string req);
        int got;
        @(negedge clk);
        mcand_i  = a[N-1:0];
        mplier_i = b[N-1:0];
        @(negedge clk);
        got = int'($signed(product_o));
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: %0d * %0d gave %0d, expected %0d", req, a, b, got, exp);
        end
    endtask

    task automatic test_reset;
        // R2: hold reset with non-zero operands; the product must stay zero.
        @(negedge clk);
        mcand_i  = 5'd7;
        mplier_i = 5'd9;
        rst_n    = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n_checks++;
        if (product_o != '0) begin
            n_fail++;
            $display("FAIL R2: product %0h, expected 0", product_o);
        end
        rst_n = 1'b1;
    endtask

    task automatic test_examples;
        apply_check(14, 11, 154, "R5");
        apply_check(-14, 11, -154, "R4");
        apply_check(-1, 15, -15, "R4");
    endtask

    task automatic test_neg_multiplier;
        apply_check(14, -11, -154, "R6");
        apply_check(-14, -11, 154, "R6");
        apply_check(-1, -1, 1, "R6");
    endtask

    task automatic test_most_negative;
        apply_check(-16, -16, 256, "R7");
        apply_check(15, -16, -240, "R7");
        apply_check(-16, 15, -240, "R7");
    endtask

    task automatic test_zero;
        apply_check(0, -16, 0, "R8");
        apply_check(-16, 0, 0, "R8");
    endtask

    task automatic test_hold;
        // R9, R1: keep the operands and check the value over two more cycles.
        apply_check(-7, 13, -91, "R1");
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            n_checks++;
            if (int'($signed(product_o)) != -91) begin
                n_fail++;
                $display("FAIL R9: held product %0d, expected -91", int'($signed(product_o)));
            end
        end
    endtask

    task automatic test_exhaustive;
        // R3: every operand pair.
        for (int a = -(1 << (N-1)); a < (1 << (N-1)); a++) begin
            for (int b = -(1 << (N-1)); b < (1 << (N-1)); b++) begin
                apply_check(a, b, a * b, "R3");
            end
        end
    endtask

    initial begin
        test_reset();
        test_examples();
        test_neg_multiplier();
        test_most_negative();
        test_zero();
        test_hold();
        test_exhaustive();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule